// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits between a simple word-addressed register port and a raw NAND flash bus. Software steers the flash by hand. A mode register sets the command and address latch lines, the chip enable, a target chip select and a write gate. A data register turns each access into one timed strobe on the flash bus. A write drives the low data bits out under a write strobe. A read pulses the read strobe and returns the sampled bus value.

Strobe width and data hold time are programmable in clock cycles through a timing register. While a strobe or its hold window is running, the register port holds off any new access, so software never has to poll for bus completion. A status register reflects the flash ready/busy line. A self-clearing reset register returns the controller to its power-up state.

Every access is a request held by the host until a one-cycle acknowledge. The state machine has four states:
- `ST_IDLE` accepts requests.
- `ST_STROBE` holds a strobe low.
- `ST_HOLD` keeps write data on the bus after the strobe.
- `ST_SRST` runs the soft reset.

The transitions are:
- *accept*: `ST_IDLE`→`ST_STROBE` on a gated data write or any data read.
- *strobe_done*: `ST_STROBE`→`ST_HOLD`.
- *hold_done*: `ST_HOLD`→`ST_IDLE`.
- *srst_begin*: `ST_IDLE`→`ST_SRST`.
- *srst_done*: `ST_SRST`→`ST_IDLE`.

Top module: `nfc_bus_ctrl`

## Requirements
- R1: After hardware reset all chip enables are high, both latch lines are low, both strobes are high and the data bus is not driven. The mode register (byte offset 0x04) reads 0x00 and the timing register (offset 0x14) reads 0xFF.
- R2: Mode bit 0 drives `nand_cle` and mode bit 1 drives `nand_ale`, from the cycle the write is acknowledged. The mode and timing registers read back the value last written.
- R3: When mode bit 4 is 1, only the chip enable numbered by mode bits 3:2 is driven low. When mode bit 4 is 0, all chip enables are high.
- R4: A write to the data register (offset 0x00) while mode bit 7 is 1 works as follows. The write is acknowledged one cycle after acceptance. `nand_we_n` goes low for exactly (timing bits 3:0 + 1) cycles with the written low byte on `nand_dq_out`. `nand_dq_oe` stays high for (timing bits 7:4 + 2) further cycles.
- R5: A data-register write while mode bit 7 is 0 is acknowledged without any strobe. The bus is not driven, and the next access is not delayed.
- R6: A data-register read pulses `nand_re_n` low for (timing bits 3:0 + 1) cycles. It returns the bus value sampled in the last strobe cycle, zero-extended. The acknowledge comes with the end of the strobe.
- R7: An access requested during a strobe or hold window is not acknowledged until the controller has returned to idle.
- R8: The status register (offset 0x08) reads bit 7 = 1 while `nand_rb_n` is low and 0 otherwise. All its other bits read 0.
- R9: Writing 1 to bit 0 of the reset register (offset 0x18) starts a soft reset lasting RST_CYC cycles. The soft reset clears the mode register and sets the timing register to 0xFF. During it the reset register reads 1 and other accesses wait; afterwards it reads 0.
- R10: Offsets 0x0C and 0x10 read 0, and writes to them change nothing.
- R11: Every register access other than a data read is acknowledged one cycle after acceptance. The acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the register |
| host_wdata | input | HOST_W | Write data |
| host_ack | output | 1 | One-cycle access acknowledge |
| host_rdata | output | HOST_W | Read data, valid with `host_ack` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | DQ_W | Flash data bus, outbound |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | DQ_W | Flash data bus, inbound |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
A wrong state or counter value shows on the strobe pins first, within one strobe. A stuck counter gives a strobe or hold window of the wrong length. A missed transition either leaves `nand_we_n` low or leaves the bus driven into idle. The reference model in the bench tracks the latch and chip-enable pins every cycle, measures each strobe and hold window on its falling edge, and times every acknowledge. A corrupted mode or timing register therefore appears as a pin mismatch in the next cycle, or as a wrong latency on the next access.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2,
        ST_SRST   = 2'd3
    } nfc_state_e;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_ISTAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_TIME  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_RST   = 5'h18;

    localparam int MODE_CLE  = 0;
    localparam int MODE_ALE  = 1;
    localparam int MODE_CE   = 4;
    localparam int MODE_GATE = 7;

    localparam int STAT_BUSY = 7;

endpackage

// File: rtl/nfc_regs.sv
module nfc_regs #(
    parameter logic [7:0] MODE_RST = 8'h00,
    parameter logic [7:0] TIME_RST = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_clr,
    input  logic       mode_we,
    input  logic       time_we,
    input  logic [7:0] wbyte,
    output logic [7:0] mode_q,
    output logic [7:0] time_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            time_q <= TIME_RST;
        end else if (soft_clr) begin
            mode_q <= MODE_RST;
            time_q <= TIME_RST;
        end else begin
            if (mode_we) mode_q <= wbyte;
            if (time_we) time_q <= wbyte;
        end
    end

endmodule

// File: rtl/nfc_pins.sv
module nfc_pins import nfc_pkg::*; #(
    parameter int NUM_CS = 4
) (
    input  logic [4:0]        mode_lo,
    output logic              cle,
    output logic              ale,
    output logic [NUM_CS-1:0] ce_n
);

    logic [1:0] cs_field;

    assign cs_field = mode_lo[3:2];
    assign cle      = mode_lo[MODE_CLE];
    assign ale      = mode_lo[MODE_ALE];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        assign ce_n[g] = !(mode_lo[MODE_CE] && (cs_field == 2'(g)));
    end

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq import nfc_pkg::*; #(
    parameter int DQ_W    = 8,
    parameter int HOST_W  = 32,
    parameter int RST_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DQ_W-1:0]   wdata,
    output logic              host_ack,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              gate,
    input  logic [7:0]        mode_q,
    input  logic [7:0]        time_q,
    output logic              mode_we,
    output logic              time_we,
    output logic              soft_clr,
    input  logic              rb_n,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              we_n,
    output logic              re_n,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out
);

    localparam int CNT_MAX = (RST_CYC > 17) ? RST_CYC : 17;
    localparam int CNT_W   = $clog2(CNT_MAX);

    nfc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_wr_q;
    logic              ack_q;
    logic [HOST_W-1:0] rdata_q;
    logic [DQ_W-1:0]   dq_q;

    logic hit_data, hit_mode, hit_time, hit_stat, hit_rst;
    logic take, start_strobe, start_srst, srst_rd, cnt_zero;
    logic [HOST_W-1:0] reg_rd;

    assign hit_data = (host_addr == OFS_DATA);
    assign hit_mode = (host_addr == OFS_MODE);
    assign hit_time = (host_addr == OFS_TIME);
    assign hit_stat = (host_addr == OFS_STAT);
    assign hit_rst  = (host_addr == OFS_RST);

    assign take         = (state_q == ST_IDLE) && host_req && !ack_q;
    assign start_strobe = take && hit_data && (!host_wr || gate);
    assign start_srst   = take && host_wr && hit_rst && wdata[0];
    assign srst_rd      = (state_q == ST_SRST) && host_req && !ack_q
                          && !host_wr && hit_rst;
    assign cnt_zero     = (cnt_q == '0);

    // Register read mux for idle-time reads (data reads go through a strobe)
    always_comb begin
        reg_rd = '0;
        if (hit_mode)      reg_rd = HOST_W'(mode_q);
        else if (hit_time) reg_rd = HOST_W'(time_q);
        else if (hit_stat) reg_rd[STAT_BUSY] = !rb_n;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_srst)        state_d = ST_SRST;    // srst_begin
                else if (start_strobe) state_d = ST_STROBE;  // accept
            end
            ST_STROBE: if (cnt_zero) state_d = ST_HOLD;      // strobe_done
            ST_HOLD:   if (cnt_zero) state_d = ST_IDLE;      // hold_done
            ST_SRST:   if (cnt_zero) state_d = ST_IDLE;      // srst_done
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter, acknowledge and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
            dq_q    <= '0;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        if (host_wr) begin
                            ack_q <= 1'b1;
                            if (start_strobe) begin
                                is_wr_q <= 1'b1;
                                dq_q    <= wdata;
                                cnt_q   <= CNT_W'(time_q[3:0]);
                            end
                            if (start_srst) cnt_q <= CNT_W'(RST_CYC - 1);
                        end else if (hit_data) begin
                            is_wr_q <= 1'b0;
                            cnt_q   <= CNT_W'(time_q[3:0]);
                        end else begin
                            ack_q   <= 1'b1;
                            rdata_q <= reg_rd;
                        end
                    end
                end
                ST_STROBE: begin
                    if (cnt_zero) begin
                        cnt_q <= CNT_W'(time_q[7:4]) + CNT_W'(1);
                        if (!is_wr_q) begin
                            ack_q   <= 1'b1;
                            rdata_q <= HOST_W'(dq_in);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_SRST: begin
                    if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
                    if (srst_rd) begin
                        ack_q   <= 1'b1;
                        rdata_q <= HOST_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        we_n       = !((state_q == ST_STROBE) && is_wr_q);
        re_n       = !((state_q == ST_STROBE) && !is_wr_q);
        dq_oe      = ((state_q == ST_STROBE) || (state_q == ST_HOLD)) && is_wr_q;
        dq_out     = dq_q;
        host_ack   = ack_q;
        host_rdata = rdata_q;
        mode_we    = take && host_wr && hit_mode;
        time_we    = take && host_wr && hit_time;
        soft_clr   = start_srst;
    end

endmodule

// File: rtl/nfc_bus_ctrl.sv
module nfc_bus_ctrl import nfc_pkg::*; #(
    parameter int DQ_W    = 8,
    parameter int NUM_CS  = 4,
    parameter int HOST_W  = 32,
    parameter int RST_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [HOST_W-1:0] host_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DQ_W-1:0]   nand_dq_in,
    input  logic              nand_rb_n
);

    localparam int WB = (DQ_W > 8) ? DQ_W : 8;

    logic [7:0] mode_q, time_q;
    logic       mode_we, time_we, soft_clr;
    logic       unused_bits;

    assign unused_bits = ^{host_wdata[HOST_W-1:WB], mode_q[6:5]};

    nfc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .mode_we  (mode_we),
        .time_we  (time_we),
        .wbyte    (host_wdata[7:0]),
        .mode_q   (mode_q),
        .time_q   (time_q)
    );

    nfc_seq #(
        .DQ_W    (DQ_W),
        .HOST_W  (HOST_W),
        .RST_CYC (RST_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .wdata      (host_wdata[DQ_W-1:0]),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .gate       (mode_q[MODE_GATE]),
        .mode_q     (mode_q),
        .time_q     (time_q),
        .mode_we    (mode_we),
        .time_we    (time_we),
        .soft_clr   (soft_clr),
        .rb_n       (nand_rb_n),
        .dq_in      (nand_dq_in),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_oe      (nand_dq_oe),
        .dq_out     (nand_dq_out)
    );

    nfc_pins #(
        .NUM_CS (NUM_CS)
    ) u_pins (
        .mode_lo (mode_q[4:0]),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .ce_n    (nand_ce_n)
    );

endmodule

// File: rtl/nfc_bus_ctrl_chk.sv
module nfc_bus_ctrl_chk #(
    parameter int NUM_CS = 4,
    parameter int DQ_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_dq_oe,
    input logic [DQ_W-1:0]   nand_dq_out,
    input logic [NUM_CS-1:0] nand_ce_n,
    input logic              mode_ce,
    input logic [3:0]        spw
);

    logic [4:0] wlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wlen <= '0;
        else if (!nand_we_n) wlen <= wlen + 5'd1;
        else                 wlen <= '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R6
    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n)); // R3
    AST_CE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ce |-> (&nand_ce_n)); // R3
    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe); // R4
    AST_HOLD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> nand_dq_oe); // R4
    AST_DQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$fell(nand_we_n)) |-> $stable(nand_dq_out)); // R4
    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (wlen == ({1'b0, spw} + 5'd1))); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R11

endmodule

bind nfc_bus_ctrl nfc_bus_ctrl_chk #(
    .NUM_CS (NUM_CS),
    .DQ_W   (DQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ack    (host_ack),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_out (nand_dq_out),
    .nand_ce_n   (nand_ce_n),
    .mode_ce     (mode_q[4]),
    .spw         (time_q[3:0])
);

// File: tb/nfc_bus_ctrl_test.sv
module nfc_bus_ctrl_test;

    localparam logic [4:0] A_DATA = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                           A_IST = 5'h0C, A_IMK = 5'h10, A_TIME = 5'h14, A_RST = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n, req, wr, ack;
    logic [4:0]  addr;
    logic [31:0] wdata, rdata;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;
    logic [3:0]  nand_ce_n;
    logic [7:0]  nand_dq_out, nand_dq_in;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0;
    bit mon_on = 0;

    // reference model state
    logic [7:0] m_mode = 8'h00, m_time = 8'hFF, exp_dq = 8'h00;
    int wlen = 0, rlen = 0, hlen = 0;
    bit hold_trk = 0, prev_ack = 0;

    always #4 clk = ~clk;

    nfc_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr), .host_addr(addr),
        .host_wdata(wdata), .host_ack(ack), .host_rdata(rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit w, input logic [4:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int n);
        @(posedge clk); #1;
        req = 1'b1; wr = w; addr = a; wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ack && n < 200);
        if (!ack) chk(1'b0, "access timeout", n, 0);
        rd = rdata;
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    // Cycle-by-cycle reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            logic [3:0] exp_ce;
            if (ack && req && wr) begin
                if (addr == A_MODE)                   m_mode = wdata[7:0];
                else if (addr == A_TIME)              m_time = wdata[7:0];
                else if (addr == A_RST && wdata[0]) begin m_mode = 8'h00; m_time = 8'hFF; end
                else if (addr == A_DATA && m_mode[7]) exp_dq = wdata[7:0];
            end
            exp_ce = 4'hF;
            if (m_mode[4]) exp_ce[m_mode[3:2]] = 1'b0;
            chk({nand_cle, nand_ale} == {m_mode[0], m_mode[1]}, "R2 latch pins",
                {nand_cle, nand_ale}, {m_mode[0], m_mode[1]});
            chk(nand_ce_n == exp_ce, "R3 chip enables", nand_ce_n, exp_ce);
            chk(!(prev_ack && ack), "R11 ack pulse", 1, 0);
            prev_ack = ack;
            // hold window after a write strobe
            if (hold_trk) begin
                if (nand_dq_oe && nand_we_n) hlen++;
                else begin
                    chk(hlen == m_time[7:4] + 2, "R4 hold width", hlen, m_time[7:4] + 2);
                    hold_trk = 0;
                end
            end
            if (!nand_we_n) begin
                wlen++;
                chk(nand_dq_oe && nand_dq_out == exp_dq, "R4 write data", nand_dq_out, exp_dq);
            end else if (wlen > 0) begin
                chk(wlen == m_time[3:0] + 1, "R4 strobe width", wlen, m_time[3:0] + 1);
                wlen = 0; n_wr++; hold_trk = 1; hlen = 1;
            end
            if (!nand_re_n) rlen++;
            else if (rlen > 0) begin
                chk(rlen == m_time[3:0] + 1, "R6 read strobe width", rlen, m_time[3:0] + 1);
                rlen = 0; n_rd++;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        int n, s0;
        rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        nand_dq_in = '0; nand_rb_n = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1; mon_on = 1;
        @(negedge clk);
        chk(nand_ce_n == 4'hF && !nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_dq_oe,
            "R1 idle pins", {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}, 8'b1111_0011 << 0);
        acc(0, A_TIME, 0, rd, n); chk(rd == 32'hFF, "R1 timing reset", rd, 32'hFF);
        acc(0, A_MODE, 0, rd, n); chk(rd == 32'h0, "R1 mode reset", rd, 0);
        chk(n == 2, "R11 register ack latency", n, 2);

        // R2 latch control and readback
        acc(1, A_MODE, 32'h03, rd, n);
        @(negedge clk); chk(nand_cle && nand_ale, "R2 both latches", {nand_cle, nand_ale}, 2'b11);
        acc(0, A_MODE, 0, rd, n); chk(rd == 32'h03, "R2 mode readback", rd, 3);
        acc(1, A_MODE, 32'h01, rd, n);
        @(negedge clk); chk(nand_cle && !nand_ale, "R2 cle only", {nand_cle, nand_ale}, 2'b10);

        // R3 chip select decode
        acc(1, A_MODE, 32'h18, rd, n);
        @(negedge clk); chk(nand_ce_n == 4'b1011, "R3 select 2", nand_ce_n, 4'b1011);
        acc(1, A_MODE, 32'h08, rd, n);
        @(negedge clk); chk(nand_ce_n == 4'hF, "R3 deselected", nand_ce_n, 4'hF);
        acc(1, A_MODE, 32'h1C, rd, n);
        @(negedge clk); chk(nand_ce_n == 4'b0111, "R3 select 3", nand_ce_n, 4'b0111);

        // R4 gated write, R7 stall behind it
        acc(1, A_TIME, 32'h21, rd, n);
        acc(0, A_TIME, 0, rd, n); chk(rd == 32'h21, "R2 timing readback", rd, 32'h21);
        acc(1, A_MODE, 32'h90, rd, n);
        s0 = n_wr;
        acc(1, A_DATA, 32'h1A5, rd, n); chk(n == 2, "R4 write ack latency", n, 2);
        acc(0, A_STAT, 0, rd, n); chk(n == 6, "R7 stall behind strobe", n, 6);
        chk(rd == 32'h0, "R8 ready status", rd, 0);
        chk(n_wr == s0 + 1, "R4 one strobe", n_wr, s0 + 1);

        // R5 write with gate clear
        acc(1, A_MODE, 32'h10, rd, n);
        s0 = n_wr;
        acc(1, A_DATA, 32'h5A, rd, n); chk(n == 2, "R5 ack", n, 2);
        acc(0, A_MODE, 0, rd, n); chk(n == 2, "R5 no stall", n, 2);
        repeat (20) @(negedge clk);
        chk(n_wr == s0 && !nand_dq_oe, "R5 no strobe", n_wr, s0);

        // R6 data read
        nand_dq_in = 8'h3C; s0 = n_rd;
        acc(0, A_DATA, 0, rd, n);
        chk(rd == 32'h3C, "R6 read data", rd, 32'h3C);
        chk(n == 4, "R6 read latency", n, 4);
        chk(n_rd == s0 + 1, "R6 one read strobe", n_rd, s0 + 1);

        // R8 busy status
        nand_rb_n = 1'b0;
        acc(0, A_STAT, 0, rd, n); chk(rd == 32'h80, "R8 busy status", rd, 32'h80);
        nand_rb_n = 1'b1;

        // R10 reserved offsets
        acc(1, A_IST, 32'hFF, rd, n);
        acc(1, A_IMK, 32'hFF, rd, n);
        acc(0, A_IST, 0, rd, n); chk(rd == 0, "R10 offset 0x0C", rd, 0);
        acc(0, A_IMK, 0, rd, n); chk(rd == 0, "R10 offset 0x10", rd, 0);
        acc(0, A_MODE, 0, rd, n); chk(rd == 32'h10, "R10 mode untouched", rd, 32'h10);
        acc(0, A_TIME, 0, rd, n); chk(rd == 32'h21, "R10 timing untouched", rd, 32'h21);

        // R7 back-to-back data writes
        acc(1, A_MODE, 32'h90, rd, n);
        acc(1, A_DATA, 32'h11, rd, n);
        acc(1, A_DATA, 32'h22, rd, n); chk(n == 6, "R7 second write waits", n, 6);

        // R9 soft reset
        acc(1, A_MODE, 32'h13, rd, n);
        acc(1, A_RST, 32'h1, rd, n);
        acc(0, A_RST, 0, rd, n); chk(rd == 1, "R9 reset in progress", rd, 1);
        acc(0, A_MODE, 0, rd, n); chk(rd == 0, "R9 mode cleared", rd, 0);
        chk(n > 2, "R9 access waits", n, 3);
        acc(0, A_RST, 0, rd, n); chk(rd == 0, "R9 reset bit cleared", rd, 0);
        acc(0, A_TIME, 0, rd, n); chk(rd == 32'hFF, "R9 timing default", rd, 32'hFF);

        // slowest timing: strobe 16, hold 17
        acc(1, A_MODE, 32'h90, rd, n);
        s0 = n_wr;
        acc(1, A_DATA, 32'hC3, rd, n);
        acc(0, A_STAT, 0, rd, n); chk(n == 33, "R7 slow stall", n, 33);
        chk(n_wr == s0 + 1, "R4 slow strobe", n_wr, s0 + 1);
        nand_dq_in = 8'h81;
        acc(0, A_DATA, 0, rd, n);
        chk(rd == 32'h81, "R6 slow read data", rd, 32'h81);
        chk(n == 18, "R6 slow read latency", n, 18);

        repeat (40) @(negedge clk);
        mon_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule